// File: doc/BRIEF.md
# Next Program Counter Sequencer

This block owns the program counter of a small 32-bit load/store processor and decides, every cycle, where the next fetch goes. The decode stage gives it a flow class together with the low 26 bits of the current instruction, an equality flag from the register comparator and a 32-bit register value. From these it forms the sequential address, a PC-relative branch target, a region-local jump target or a register-indirect target. It also produces the return address and a write strobe for the link register.

The counter advances on every clock edge unless the pipeline stalls it. A synchronous reset clears it to zero. A register-indirect target is used exactly as given. When that target is not word aligned, a flag is raised during the cycle in which the jump is accepted.

Top module: `npc_sequencer`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) sets `pc_o` to 0x00000000.
- R2: Flow code 0 (sequential), and the unused codes 6 and 7, move the PC to PC + 4.
- R3: Flow code 1 (branch when equal) goes to the branch target when `regs_equal_i` is 1 and to PC + 4 when it is 0.
- R4: Flow code 2 (branch when different) goes to the branch target when `regs_equal_i` is 0 and to PC + 4 when it is 1.
- R5: The branch target is PC + 4 plus the sign-extended 16-bit field `instr_low_i[15:0]` multiplied by 4, so negative offsets go backwards.
- R6: Flow code 3 (jump) goes to {bits 31:28 of PC + 4, `instr_low_i[25:0]`, 2'b00}.
- R7: Flow code 4 (jump with link) jumps as in R6 and, in the same cycle, drives `link_we_o` = 1, `link_addr_o` = 31 and `link_data_o` = PC + 4. `link_we_o` is 0 for every other code.
- R8: Flow code 5 (register jump) loads all 32 bits of `reg_target_i` into the PC.
- R9: A register jump whose target has a non-zero value in bits 1:0 still loads that target unchanged, and `misalign_o` is 1 for that cycle only. For aligned targets and all other codes `misalign_o` is 0.
- R10: While `stall_i` is 1 the PC keeps its value, `next_pc_o` equals `pc_o`, and neither `link_we_o` nor `misalign_o` is raised.
- R11: `next_pc_o` shows the value that `pc_o` takes at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Holds the PC and suppresses side effects |
| flow_i | input | 3 | Flow class: 0 seq, 1 branch-equal, 2 branch-different, 3 jump, 4 jump-link, 5 register jump |
| instr_low_i | input | 26 | Low 26 bits of the current instruction word |
| regs_equal_i | input | 1 | Comparator result: the two source registers are equal |
| reg_target_i | input | 32 | Register value used by a register jump |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address the PC takes at the next edge |
| link_we_o | output | 1 | Write strobe for the return-address register |
| link_addr_o | output | 5 | Return-address register index (31) |
| link_data_o | output | 32 | Return address, PC + 4 |
| misalign_o | output | 1 | Register jump to a non-word-aligned address |

## Verification
The assertions assume that all inputs are stable and known from the first edge after reset onward. They also assume that a stall cycle presents the same kind of instruction again, so nothing depends on inputs sampled during a stall. The bench drives every input shortly after a rising edge and keeps it until the next one, so each class is presented for exactly one accepted cycle. Address arithmetic wraps modulo 2^32 in both the design and the bench's model. The bench therefore lets backward offsets and high-region register jumps carry the PC across zero and across region boundaries freely.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [2:0] {
      FLOW_SEQ  = 3'd0,
      FLOW_BEQ  = 3'd1,
      FLOW_BNE  = 3'd2,
      FLOW_JMP  = 3'd3,
      FLOW_JAL  = 3'd4,
      FLOW_JR   = 3'd5,
      FLOW_RSV6 = 3'd6,
      FLOW_RSV7 = 3'd7
   } flow_e;
endpackage

// File: rtl/npc_branch_calc.sv
module npc_branch_calc #(
   parameter int ADDR_W    = 32,
   parameter int OFF_W     = 16,
   parameter int WORD_BYTES = 4
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [OFF_W-1:0]  off_i,
   output logic [ADDR_W-1:0] pc_seq_o,
   output logic [ADDR_W-1:0] br_tgt_o
);
   localparam int EXT_W = ADDR_W - OFF_W - 2;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   if (OFF_W + 2 > ADDR_W) begin : g_bad_off
      $error("npc_branch_calc: offset field too wide for address");
   end

   logic [ADDR_W-1:0] off_bytes;

   if (EXT_W > 0) begin : g_ext
      assign off_bytes = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
   end else begin : g_noext
      assign off_bytes = {off_i, 2'b00};
   end

   assign pc_seq_o = pc_i + STEP;
   assign br_tgt_o = pc_seq_o + off_bytes;
endmodule

// File: rtl/npc_jump_calc.sv
module npc_jump_calc #(
   parameter int ADDR_W = 32,
   parameter int TGT_W  = 26
) (
   input  logic [ADDR_W-1:0] pc_seq_i,
   input  logic [TGT_W-1:0]  tgt_i,
   output logic [ADDR_W-1:0] jmp_tgt_o
);
   localparam int REGION_W = ADDR_W - TGT_W - 2;

   if (REGION_W < 0) begin : g_bad_tgt
      $error("npc_jump_calc: target field too wide for address");
   end

   if (REGION_W > 0) begin : g_region
      logic unused_low;
      assign unused_low = ^pc_seq_i[ADDR_W-REGION_W-1:0];
      assign jmp_tgt_o = {pc_seq_i[ADDR_W-1 -: REGION_W], tgt_i, 2'b00};
   end else begin : g_flat
      logic unused_all;
      assign unused_all = ^pc_seq_i;
      assign jmp_tgt_o = {tgt_i, 2'b00};
   end
endmodule

// File: rtl/npc_select.sv
module npc_select
   import npc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  flow_e             flow_i,
   input  logic              go_i,
   input  logic              eq_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] pc_seq_i,
   input  logic [ADDR_W-1:0] br_tgt_i,
   input  logic [ADDR_W-1:0] jmp_tgt_i,
   input  logic [ADDR_W-1:0] reg_tgt_i,
   output logic [ADDR_W-1:0] next_pc_o,
   output logic              link_we_o,
   output logic              misalign_o
);
   logic [ADDR_W-1:0] target;

   always_comb begin
      case (flow_i)
         FLOW_BEQ: target = eq_i  ? br_tgt_i : pc_seq_i;
         FLOW_BNE: target = !eq_i ? br_tgt_i : pc_seq_i;
         FLOW_JMP,
         FLOW_JAL: target = jmp_tgt_i;
         FLOW_JR:  target = reg_tgt_i;
         default:  target = pc_seq_i;
      endcase
   end

   assign next_pc_o  = go_i ? target : pc_i;
   assign link_we_o  = go_i && (flow_i == FLOW_JAL);
   assign misalign_o = go_i && (flow_i == FLOW_JR) && (reg_tgt_i[1:0] != 2'b00);
endmodule

// File: rtl/npc_sequencer.sv
module npc_sequencer
   import npc_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 16,
   parameter int TGT_W    = 26,
   parameter int RA_W     = 5,
   parameter int LINK_REG = 31
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              stall_i,
   input  logic [2:0]        flow_i,
   input  logic [TGT_W-1:0]  instr_low_i,
   input  logic              regs_equal_i,
   input  logic [ADDR_W-1:0] reg_target_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] next_pc_o,
   output logic              link_we_o,
   output logic [RA_W-1:0]   link_addr_o,
   output logic [ADDR_W-1:0] link_data_o,
   output logic              misalign_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

   if (OFF_W > TGT_W) begin : g_bad_fields
      $error("npc_sequencer: offset field must sit inside target field");
   end
   if (LINK_REG >= (1 << RA_W)) begin : g_bad_link
      $error("npc_sequencer: link register index out of range");
   end

   logic [ADDR_W-1:0] pc_q, pc_seq, br_tgt, jmp_tgt, nxt;
   logic              go, started_q;
   flow_e             flow;

   assign flow = flow_e'(flow_i);
   assign go   = !stall_i && !rst_i;

   npc_branch_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WORD_BYTES(4)) u_br (
      .pc_i     (pc_q),
      .off_i    (instr_low_i[OFF_W-1:0]),
      .pc_seq_o (pc_seq),
      .br_tgt_o (br_tgt)
   );

   npc_jump_calc #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_jmp (
      .pc_seq_i  (pc_seq),
      .tgt_i     (instr_low_i),
      .jmp_tgt_o (jmp_tgt)
   );

   npc_select #(.ADDR_W(ADDR_W)) u_sel (
      .flow_i     (flow),
      .go_i       (go),
      .eq_i       (regs_equal_i),
      .pc_i       (pc_q),
      .pc_seq_i   (pc_seq),
      .br_tgt_i   (br_tgt),
      .jmp_tgt_i  (jmp_tgt),
      .reg_tgt_i  (reg_target_i),
      .next_pc_o  (nxt),
      .link_we_o  (link_we_o),
      .misalign_o (misalign_o)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pc_q      <= '0;
         started_q <= 1'b1;
      end else begin
         pc_q      <= nxt;
      end
   end

   assign pc_o        = pc_q;
   assign next_pc_o   = nxt;
   assign link_addr_o = RA_W'(LINK_REG);
   assign link_data_o = pc_seq;

   p_reset_zero_r1: assert property (@(posedge clk_i)
      rst_i |=> (pc_o == '0));

   p_seq_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (started_q === 1'b1 && !stall_i && flow_i == 3'd0) |=> (pc_o == $past(pc_o) + STEP));

   p_jal_region_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (started_q === 1'b1 && link_we_o) |=> (pc_o[ADDR_W-1 -: 4] == $past(link_data_o[ADDR_W-1 -: 4])));

   p_jr_load_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (started_q === 1'b1 && !stall_i && flow_i == 3'd5) |=> (pc_o == $past(reg_target_i)));

   p_flag_cause_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (started_q === 1'b1 && misalign_o) |-> (flow_i == 3'd5 && reg_target_i[1:0] != 2'b00));

   p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (started_q === 1'b1 && stall_i) |=> $stable(pc_o));

   p_stall_quiet_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (started_q === 1'b1 && stall_i) |-> (!link_we_o && !misalign_o));

   p_follow_next_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      (started_q === 1'b1) |=> (pc_o == $past(next_pc_o)));
endmodule

// File: tb/npc_sequencer_tb.sv
module npc_sequencer_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst, stall, eq, link_we, misalign;
   logic [2:0]  flow;
   logic [25:0] ilow;
   logic [31:0] rtgt, pc, npc, ldata;
   logic [4:0]  laddr;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;
   logic [31:0] pc_m;

   always #(CLK_PERIOD/2) clk = ~clk;

   npc_sequencer u_dut (
      .clk_i(clk), .rst_i(rst), .stall_i(stall), .flow_i(flow),
      .instr_low_i(ilow), .regs_equal_i(eq), .reg_target_i(rtgt),
      .pc_o(pc), .next_pc_o(npc), .link_we_o(link_we),
      .link_addr_o(laddr), .link_data_o(ldata), .misalign_o(misalign)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_next(input logic [31:0] p, input logic [2:0] f,
                                               input logic [25:0] il, input logic e,
                                               input logic [31:0] rt);
      logic [31:0] p4, br;
      p4 = p + 32'd4;
      br = p4 + 32'($signed(il[15:0])) * 32'd4;
      case (f)
         3'd1: return e ? br : p4;
         3'd2: return e ? p4 : br;
         3'd3, 3'd4: return {p4[31:28], il, 2'b00};
         3'd5: return rt;
         default: return p4;
      endcase
   endfunction

   // Call just after a rising edge; presents one instruction for one cycle.
   task automatic step(input logic [2:0] f, input logic [25:0] il, input logic e,
                       input logic [31:0] rt, input logic st, input string tag);
      logic [31:0] exp;
      flow = f; ilow = il; eq = e; rtgt = rt; stall = st;
      @(negedge clk);
      exp = st ? pc_m : model_next(pc_m, f, il, e, rt);
      chk(npc == exp, {tag, " R11 next_pc"}, npc, exp);
      chk(link_we == (!st && f == 3'd4), {tag, " R7 link_we"}, 32'(link_we), 32'(!st && f == 3'd4));
      if (!st && f == 3'd4) begin
         chk(laddr == 5'd31, {tag, " R7 link_addr"}, 32'(laddr), 32'd31);
         chk(ldata == pc_m + 32'd4, {tag, " R7 link_data"}, ldata, pc_m + 32'd4);
      end
      chk(misalign == (!st && f == 3'd5 && rt[1:0] != 2'b00), {tag, " R9 misalign"},
          32'(misalign), 32'(!st && f == 3'd5 && rt[1:0] != 2'b00));
      @(posedge clk); #1;
      chk(pc == exp, {tag, " pc"}, pc, exp);
      pc_m = exp;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      chk(pc == 32'd0, "R1 reset pc", pc, 32'd0);
      rst = 1'b0;
      pc_m = 32'd0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] offs [8];
      logic [25:0] tgts [4];
      offs[0] = 16'h0000; offs[1] = 16'h0001; offs[2] = 16'd25;   offs[3] = 16'hFFFF;
      offs[4] = 16'hFFE7; offs[5] = 16'h7FFF; offs[6] = 16'h8000; offs[7] = 16'h0100;
      tgts[0] = 26'h0000000; tgts[1] = 26'h3FFFFFF; tgts[2] = 26'h1234567; tgts[3] = 26'h0000271;
      rst = 1'b1; stall = 1'b0; flow = 3'd0; ilow = '0; eq = 1'b0; rtgt = '0;
      @(posedge clk); #1;
      do_reset();

      // R2: sequential and the spare codes
      for (int i = 0; i < 4; i++) step(3'd0, 26'(i * 7919), 1'(i), 32'hDEAD0000, 1'b0, "R2 seq");
      step(3'd6, 26'h3FFFFFF, 1'b1, 32'h0, 1'b0, "R2 code6");
      step(3'd7, 26'h0008000, 1'b0, 32'h0, 1'b0, "R2 code7");

      // R3 R4 R5: both branch kinds, both comparator values, offset sweep
      for (int o = 0; o < 8; o++)
         for (int k = 1; k <= 2; k++)
            for (int e = 0; e < 2; e++)
               step(3'(k), {10'h2A5, offs[o]}, 1'(e), 32'h0, 1'b0, "R3 R4 R5 branch");

      // R6 R7: jumps in a high region, then across a region edge
      step(3'd5, 26'h0, 1'b0, 32'hF0000010, 1'b0, "R8 jr high");
      for (int t = 0; t < 4; t++) step(3'd3, tgts[t], 1'b0, 32'h0, 1'b0, "R6 jump");
      for (int t = 0; t < 4; t++) step(3'd4, tgts[t], 1'b1, 32'h0, 1'b0, "R7 jal");
      step(3'd5, 26'h0, 1'b0, 32'h0FFFFFFC, 1'b0, "R8 jr edge");
      step(3'd3, 26'h0000010, 1'b0, 32'h0, 1'b0, "R6 region from pc+4");
      step(3'd5, 26'h0, 1'b0, 32'h6FFFFFFC, 1'b0, "R8 jr edge2");
      step(3'd4, 26'h0000020, 1'b0, 32'h0, 1'b0, "R7 jal region");

      // R8 R9: register jumps with every low-bit pattern
      for (int lb = 0; lb < 4; lb++)
         step(3'd5, 26'h0, 1'b0, 32'h12345670 | 32'(lb), 1'b0, "R8 R9 jr");

      // R10: stall with every class
      for (int f = 0; f < 8; f++) begin
         step(3'(f), 26'h0000040, 1'b1, 32'h00000203, 1'b1, "R10 stall");
         step(3'(f), 26'h0000040, 1'b1, 32'h00000203, 1'b0, "R10 release");
      end

      // R1: reset from a non-zero PC
      do_reset();
      step(3'd0, 26'h0, 1'b0, 32'h0, 1'b0, "R1 after reset");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule